// File: doc/BRIEF.md
# Channel Status and User Bit Block Capture

This block sits behind an audio receiver that has already decoded the serial stream into frames. On every frame strobe it takes one channel status bit and one user bit from the subframe chosen by a select input. It places them in two 192-bit working images, one per bit stream. Frame number i of a block is written to bit i of its image. Byte n therefore sits in bits `[8*(n%4)+7 : 8*(n%4)]` of word n/4, and the first bit received of each byte is at the byte's bit 0.

The images that software can see change only when a whole block has been received. That block must have started with a block-start marker and run through 192 strobed frames with no new marker in between. When the frame that completes the block is taken, both working images are copied into the visible images in the same clock edge. A read never returns a mix of two blocks. A partial block is dropped when a new marker arrives early, and the visible images keep the last complete block. A combinational read port returns the six status words and the six user words. A sticky flag shows that at least one complete block has been published.

Top module: `chstat_capture`

## Requirements
- R1: After a synchronous reset, every read address returns zero and `blk_valid` is low.
- R2: Address map: addresses 0 to 5 return channel status words 0 to 5, addresses 6 to 11 return user words 0 to 5, and addresses 12 to 15 return zero. Frame i of a block is stored in bit i%32 of word i/32.
- R3: With `sub_sel` = 0 the capture takes `c_a`/`u_a`. With `sub_sel` = 1 it takes `c_b`/`u_b`.
- R4: `sub_sel` is sampled only on a strobed frame that carries `blk_start`. A change during a block has no effect until the next block start.
- R5: The strobed frame with index 191 (counted from the block-start frame as 0) publishes the whole block. The new words are readable right after the clock edge that takes that frame.
- R6: While the next block is being collected, the visible words keep the previous complete block.
- R7: A block start seen before 192 frames are counted drops the partial block and restarts at frame 0. Nothing is published for the dropped block.
- R8: Strobed frames that arrive before any block start, or after frame 191 without a new block start, are ignored.
- R9: `blk_valid` rises together with the first publish and stays high until reset.
- R10: Cycles with `frame_vld` low are ignored, including any `blk_start` or bit values driven during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe per decoded frame |
| blk_start | input | 1 | Marks the strobed frame as frame 0 of a block |
| sub_sel | input | 1 | Subframe source for the C and U bits (0 = A, 1 = B) |
| c_a | input | 1 | Channel status bit of subframe A |
| u_a | input | 1 | User bit of subframe A |
| c_b | input | 1 | Channel status bit of subframe B |
| u_b | input | 1 | User bit of subframe B |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read word, combinational from `rd_addr` |
| blk_valid | output | 1 | Sticky flag: at least one full block has been published |

## Verification
The read port has no register, so a word is due in the same cycle its address is applied. The bench sets the address on a falling edge and compares a nanosecond later. A publish is due at the rising edge that takes frame 191, and `blk_valid` rises at that same edge. The bench drives each frame on a falling edge, lowers the strobe on the next falling edge, and reads all words after that. This makes the checks land exactly one register stage after the completing frame. Checks for dropped blocks, ignored frames and idle-cycle markers read the full word set before the next block could complete, so any early publish would be seen.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int BLOCK_FRAMES = 192;
    localparam int WORD_BITS    = 32;
    localparam int WORDS_PER_CH = BLOCK_FRAMES / WORD_BITS;

    typedef enum logic {
        SUB_A = 1'b0,
        SUB_B = 1'b1
    } sub_sel_e;

    typedef struct packed {
        logic c;
        logic u;
    } cu_pair_t;

    function automatic cu_pair_t pick_pair(sub_sel_e s, cu_pair_t a, cu_pair_t b);
        return (s == SUB_B) ? b : a;
    endfunction

endpackage

// File: rtl/csc_frame_seq.sv
module csc_frame_seq
    import csc_pkg::*;
#(
    parameter int FRAMES = BLOCK_FRAMES,
    parameter int IDX_W  = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_vld,
    input  logic             blk_start,
    input  sub_sel_e         sub_sel,
    input  cu_pair_t         pair_a,
    input  cu_pair_t         pair_b,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             publish,
    output cu_pair_t         wr_pair
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

    logic [IDX_W-1:0] cnt;
    logic             armed;
    sub_sel_e         sel_q;
    sub_sel_e         cur_sel;
    logic             start_frame;

    assign start_frame = frame_vld && blk_start;
    assign cur_sel     = start_frame ? sub_sel : sel_q;
    assign wr_en       = frame_vld && (blk_start || armed);
    assign wr_idx      = start_frame ? '0 : cnt;
    assign publish     = wr_en && (wr_idx == LAST_IDX);
    assign wr_pair     = pick_pair(cur_sel, pair_a, pair_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            sel_q <= SUB_A;
        end else begin
            if (wr_en) begin
                if (publish) begin
                    cnt   <= '0;
                    armed <= 1'b0;
                end else begin
                    cnt   <= wr_idx + 1'b1;
                    armed <= 1'b1;
                end
            end
            if (start_frame) begin
                sel_q <= sub_sel;
            end
        end
    end

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_frame |=> (armed && cnt == IDX_W'(1)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !start_frame) |=> !armed);

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_frame |=> $stable(sel_q));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_IDX);

endmodule

// File: rtl/csc_block_shadow.sv
module csc_block_shadow #(
    parameter int FRAMES = 192,
    parameter int IDX_W  = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              bit_in,
    input  logic              publish,
    output logic [FRAMES-1:0] vis
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

    logic [FRAMES-1:0] work;
    logic [FRAMES-1:0] merged;

    for (genvar g = 0; g < FRAMES; g++) begin : g_bit
        logic hit;
        assign hit       = wr_en && (wr_idx == IDX_W'(g));
        assign merged[g] = hit ? bit_in : work[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                work[g] <= 1'b0;
            end else if (hit) begin
                work[g] <= bit_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis <= '0;
        end else if (publish) begin
            vis <= merged;
        end
    end

    // R6
    vis_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !publish |=> $stable(vis));

    // R5
    publish_last_chk: assert property (@(posedge clk) disable iff (rst)
        publish |-> (wr_en && wr_idx == LAST_IDX));

    // R5
    last_bit_chk: assert property (@(posedge clk) disable iff (rst)
        publish |=> (vis[FRAMES-1] == $past(bit_in)));

endmodule

// File: rtl/csc_read_mux.sv
module csc_read_mux #(
    parameter int FRAMES = 192,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4,
    parameter int NWORDS = FRAMES / WORD_W
) (
    input  logic [FRAMES-1:0] stat_img,
    input  logic [FRAMES-1:0] user_img,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] wtab [2*NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign wtab[w]          = stat_img[w*WORD_W +: WORD_W];
        assign wtab[NWORDS + w] = user_img[w*WORD_W +: WORD_W];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 2 * NWORDS; k++) begin
            if (rd_addr == ADDR_W'(k)) begin
                rd_data = wtab[k];
            end
        end
    end

endmodule

// File: rtl/chstat_capture.sv
module chstat_capture
    import csc_pkg::*;
#(
    parameter int FRAMES = BLOCK_FRAMES,
    parameter int WORD_W = WORD_BITS,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic              blk_start,
    input  logic              sub_sel,
    input  logic              c_a,
    input  logic              u_a,
    input  logic              c_b,
    input  logic              u_b,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              blk_valid
);

    localparam int IDX_W = $clog2(FRAMES);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             publish;
    cu_pair_t         wr_pair;
    cu_pair_t         pair_a;
    cu_pair_t         pair_b;
    logic [FRAMES-1:0] img [2];
    logic [1:0]        lane_bit;

    assign pair_a   = '{c: c_a, u: u_a};
    assign pair_b   = '{c: c_b, u: u_b};
    assign lane_bit = {wr_pair.u, wr_pair.c};

    csc_frame_seq #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .frame_vld(frame_vld),
        .blk_start(blk_start),
        .sub_sel  (sub_sel_e'(sub_sel)),
        .pair_a   (pair_a),
        .pair_b   (pair_b),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .publish  (publish),
        .wr_pair  (wr_pair)
    );

    for (genvar l = 0; l < 2; l++) begin : g_lane
        csc_block_shadow #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_shadow (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .wr_idx (wr_idx),
            .bit_in (lane_bit[l]),
            .publish(publish),
            .vis    (img[l])
        );
    end

    csc_read_mux #(.FRAMES(FRAMES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mux (
        .stat_img(img[0]),
        .user_img(img[1]),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_valid <= 1'b0;
        end else if (publish) begin
            blk_valid <= 1'b1;
        end
    end

    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        blk_valid |=> blk_valid);

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_valid) |-> $past(publish));

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |-> (!wr_en && !publish));

endmodule

// File: tb/sim_chstat_capture.sv
module sim_chstat_capture;

    typedef struct packed {
        logic [31:0] seed;
        logic        sel;
        logic [1:0]  gap;
        logic        toggle;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h1234_5678, 1'b0, 2'd0, 1'b0},
        '{32'hCAFE_0001, 1'b1, 2'd0, 1'b0},
        '{32'h0BAD_F00D, 1'b0, 2'd2, 1'b0},
        '{32'h7777_1111, 1'b1, 2'd1, 1'b1},
        '{32'h5A5A_A5A5, 1'b0, 2'd3, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_vld = 1'b0;
    logic        blk_start = 1'b0;
    logic        sub_sel = 1'b0;
    logic        c_a = 1'b0, u_a = 1'b0, c_b = 1'b0, u_b = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        blk_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [191:0] exp_c, exp_u, old_c, old_u;

    always #2.5 clk = ~clk;

    chstat_capture u0 (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .blk_start(blk_start),
        .sub_sel(sub_sel), .c_a(c_a), .u_a(u_a), .c_b(c_b), .u_b(u_b),
        .rd_addr(rd_addr), .rd_data(rd_data), .blk_valid(blk_valid)
    );

    function automatic logic gen(logic [31:0] seed, int i, int lane);
        logic [31:0] x;
        x = seed ^ (32'(i) * 32'h9E37_79B1) ^ (32'(lane + 1) * 32'h85EB_CA6B);
        x = x ^ (x >> 15);
        x = x * 32'h2C1B_3C6D;
        return x[17];
    endfunction

    task automatic build(input logic [31:0] seed, input logic sel);
        for (int i = 0; i < 192; i++) begin
            exp_c[i] = sel ? gen(seed, i, 2) : gen(seed, i, 0);
            exp_u[i] = sel ? gen(seed, i, 3) : gen(seed, i, 1);
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input int addr, input logic [31:0] exp);
        rd_addr = 4'(addr);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic check_all(input string req, input logic [191:0] ec, input logic [191:0] eu);
        for (int w = 0; w < 6; w++) begin
            read_chk(req, w, ec[w*32 +: 32]);
            read_chk(req, 6 + w, eu[w*32 +: 32]);
        end
    endtask

    // Frames lo..hi of a block; frame 0 carries blk_start. Starts and ends on a falling edge.
    task automatic send_range(input logic [31:0] seed, input logic sel, input int lo,
                              input int hi, input int gap, input logic toggle);
        for (int i = lo; i <= hi; i++) begin
            sub_sel   = (toggle && i >= 50) ? ~sel : sel;
            c_a       = gen(seed, i, 0);
            u_a       = gen(seed, i, 1);
            c_b       = gen(seed, i, 2);
            u_b       = gen(seed, i, 3);
            blk_start = (i == 0);
            frame_vld = 1'b1;
            @(negedge clk);
            frame_vld = 1'b0;
            blk_start = 1'b0;
            c_a = ~c_a; u_a = ~u_a; c_b = ~c_b; u_b = ~u_b;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic loose_frames(input int n);
        for (int i = 0; i < n; i++) begin
            c_a = 1'b1; u_a = 1'b1; c_b = 1'b1; u_b = 1'b1;
            frame_vld = 1'b1;
            @(negedge clk);
            frame_vld = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state on every address
        for (int a = 0; a < 16; a++) read_chk("R1", a, 32'h0);
        check("R1 valid", 32'(blk_valid), 32'h0);

        // R8: frames before any block start are ignored
        loose_frames(20);
        check_all("R8 pre-start", '0, '0);
        check("R8 valid", 32'(blk_valid), 32'h0);

        // Table walk: R2, R3, R5, R9, with R4 toggles and R10 idle gaps
        foreach (VECS[v]) begin
            build(VECS[v].seed, VECS[v].sel);
            send_range(VECS[v].seed, VECS[v].sel, 0, 191, int'(VECS[v].gap), VECS[v].toggle);
            check_all(VECS[v].toggle ? "R4 R3 R10" : "R2 R3 R5", exp_c, exp_u);
            check("R9 valid", 32'(blk_valid), 32'h1);
        end
        old_c = exp_c;
        old_u = exp_u;

        // R2: unmapped addresses read zero with data loaded
        for (int a = 12; a < 16; a++) read_chk("R2 unmapped", a, 32'h0);

        // R6: partial next block leaves visible words untouched
        send_range(32'h1111_2222, 1'b1, 0, 99, 0, 1'b0);
        check_all("R6", old_c, old_u);

        // R7: restart, then only 191 frames: still nothing published
        send_range(32'h3333_4444, 1'b0, 0, 190, 0, 1'b0);
        check_all("R7 short", old_c, old_u);

        // R7: restart again and finish a full block
        build(32'h5555_6666, 1'b1);
        send_range(32'h5555_6666, 1'b1, 0, 191, 0, 1'b0);
        check_all("R7 full", exp_c, exp_u);
        old_c = exp_c;
        old_u = exp_u;

        // R8: frames after frame 191 without a new start are ignored
        loose_frames(30);
        check_all("R8 post-block", old_c, old_u);

        // R10: blk_start without frame strobe in mid-block is ignored
        build(32'h9999_0000, 1'b0);
        send_range(32'h9999_0000, 1'b0, 0, 95, 0, 1'b0);
        blk_start = 1'b1;
        sub_sel   = 1'b1;
        repeat (3) @(negedge clk);
        blk_start = 1'b0;
        send_range(32'h9999_0000, 1'b0, 96, 191, 0, 1'b0);
        check_all("R10", exp_c, exp_u);

        // R1: reset in mid-run clears words and flag
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_all("R1 rerun", '0, '0);
        check("R1 valid rerun", 32'(blk_valid), 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule